// File: doc/BRIEF.md
# Scan-Chain Memory Access Bridge

This block sits behind a test access port and gives a debugger word-level access to a system memory bus. The port controller (not part of this block) supplies the current instruction code and three strobes, capture, shift and update, all on the rising edge of the test clock. The bridge decodes three instructions. One instruction reaches a 29-bit word address register. The other two reach a 64-bit data register: one mode only reads memory, and the other reads the old word and writes a new one in the same scan.

Memory traffic runs on the independent system clock as single bus master cycles with a fixed timeout. Requests cross from the test clock to the system clock with a toggle handshake. Results cross back the same way. Each access is started at update time, so the word that the next capture needs is already held in the test clock domain. After every data scan the address moves on by one word, so back-to-back scans walk through consecutive locations.

Top module: `jwb_bridge`

## Requirements
- R1: While either reset is asserted, and after it is released, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are low and `tdo` is 0. The first address scan after reset shifts out address 0.
- R2: Instruction codes (4-bit `ir_code`) 5, 6 and 7 select address, read and read-write access. Any other code makes capture, shift and update have no effect: no bus cycle starts and the address is unchanged.
- R3: An address scan shifts 29 bits, least significant first. Capture loads the current address into the chain. Update loads the shifted word as the new address and starts a bus read of that word.
- R4: A read scan shifts 64 bits, least significant first, and shifts out the word at the current address. The shifted-in bits are discarded and no write cycle is issued.
- R5: A read-write scan shifts out the word held at the current address. At update it writes the shifted-in 64-bit word to that same address.
- R6: Each update in read or read-write mode advances the address by one word, wrapping from 2^29-1 to 0. It also starts a read of the new address.
- R7: During a bus cycle, `wb_stb_o` equals `wb_cyc_o` and all `wb_sel_o` bits are high. `wb_we_o` is high only in write cycles. Address, data and direction stay stable until `wb_ack_i`. The cycle drops on the clock after the acknowledge.
- R8: A cycle that receives no acknowledge ends after TMO_CYCLES (default 16) system clocks. A timed-out read returns all ones to the scan chain, and a timed-out write is abandoned.
- R9: Loading an address makes the next data scan use exactly that address, whatever increments came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test-domain reset, active low |
| ir_code | input | 4 | Current instruction from the port controller |
| capture_dr | input | 1 | Capture strobe, sampled on rising `tck` |
| shift_dr | input | 1 | Shift strobe, sampled on rising `tck` |
| update_dr | input | 1 | Update strobe, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the chain |
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain reset, active low |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | 8 | Byte selects |
| wb_adr_o | output | 29 | Word address |
| wb_dat_o | output | 64 | Write data |
| wb_dat_i | input | 64 | Read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
The checks assume that a debugger leaves enough test clocks between an update and the next update or capture for the handshake to go around: two synchronizer stages each way, plus the bus cycles, plus a possible timeout. One assertion flags an update that arrives while a request is still open. The stimulus idles twelve test clocks after every update, with the test clock twenty times slower than the system clock. That gap covers a write plus a read that both time out. The bench memory answers one cycle after the strobe for the lowest sixteen words and never answers above them, which is how the timeout path is reached.

// File: rtl/jwb_pkg.sv
`timescale 1ns/1ps
package jwb_pkg;
    localparam int IR_W = 4;

    // instruction codes decoded by the bridge
    localparam logic [IR_W-1:0] OP_ADDR = 4'd5;
    localparam logic [IR_W-1:0] OP_READ = 4'd6;
    localparam logic [IR_W-1:0] OP_RDWR = 4'd7;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_GAP   = 2'd2,
        BUS_READ  = 2'd3
    } bus_state_e;
endpackage

// File: rtl/jwb_sync.sv
`timescale 1ns/1ps
module jwb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jwb_scan.sv
`timescale 1ns/1ps
module jwb_scan
    import jwb_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int DATA_W = 64
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic              ack_tgl_s,
    input  logic [DATA_W-1:0] sys_rdata,
    output logic              req_tgl,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_waddr,
    output logic [ADDR_W-1:0] req_raddr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy
);
    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rd_buf;
        logic              req_tgl;
        logic              ack_seen;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] wdata;
    } scan_s;

    scan_s st_d, st_q;

    logic sel_addr, sel_read, sel_rdwr;
    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        sel_addr  = (ir_code == OP_ADDR);
        sel_read  = (ir_code == OP_READ);
        sel_rdwr  = (ir_code == OP_RDWR);
        next_addr = st_q.addr + ADDR_W'(1);
        st_d      = st_q;

        // returned read word: latch once the answer toggle is seen
        if (ack_tgl_s != st_q.ack_seen) begin
            st_d.ack_seen = ack_tgl_s;
            st_d.rd_buf   = sys_rdata;
        end

        if (capture_dr) begin
            if (sel_addr) begin
                st_d.sr = '0;
                st_d.sr[ADDR_W-1:0] = st_q.addr;
            end else if (sel_read || sel_rdwr) begin
                st_d.sr = st_q.rd_buf;
            end
        end else if (shift_dr) begin
            if (sel_addr) begin
                st_d.sr = '0;
                st_d.sr[ADDR_W-1]   = tdi;
                st_d.sr[ADDR_W-2:0] = st_q.sr[ADDR_W-1:1];
            end else if (sel_read || sel_rdwr) begin
                st_d.sr = {tdi, st_q.sr[DATA_W-1:1]};
            end
        end else if (update_dr) begin
            if (sel_addr) begin
                st_d.addr    = st_q.sr[ADDR_W-1:0];
                st_d.we      = 1'b0;
                st_d.raddr   = st_q.sr[ADDR_W-1:0];
                st_d.req_tgl = ~st_q.req_tgl;
            end else if (sel_read) begin
                st_d.addr    = next_addr;
                st_d.we      = 1'b0;
                st_d.raddr   = next_addr;
                st_d.req_tgl = ~st_q.req_tgl;
            end else if (sel_rdwr) begin
                st_d.addr    = next_addr;
                st_d.we      = 1'b1;
                st_d.waddr   = st_q.addr;
                st_d.wdata   = st_q.sr;
                st_d.raddr   = next_addr;
                st_d.req_tgl = ~st_q.req_tgl;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tdo       = st_q.sr[0];
    assign req_tgl   = st_q.req_tgl;
    assign req_we    = st_q.we;
    assign req_waddr = st_q.waddr;
    assign req_raddr = st_q.raddr;
    assign req_wdata = st_q.wdata;
    assign cur_addr  = st_q.addr;
    assign busy      = st_q.req_tgl != st_q.ack_seen;
endmodule

// File: rtl/jwb_bus.sv
`timescale 1ns/1ps
module jwb_bus
    import jwb_pkg::*;
#(
    parameter int ADDR_W     = 29,
    parameter int DATA_W     = 64,
    parameter int TMO_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl_s,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_waddr,
    input  logic [ADDR_W-1:0] req_raddr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rdata,
    output logic              cyc,
    output logic              we,
    output logic [ADDR_W-1:0] adr,
    output logic [DATA_W-1:0] dat_o,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              ack
);
    localparam int CNT_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

    typedef struct packed {
        bus_state_e        st;
        logic              cyc;
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdata;
        logic              ack_tgl;
        logic              req_seen;
    } bus_s;

    bus_s bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        unique case (bs_q.st)
            BUS_IDLE: begin
                if (req_tgl_s != bs_q.req_seen) begin
                    bs_d.req_seen = req_tgl_s;
                    bs_d.cyc      = 1'b1;
                    bs_d.cnt      = '0;
                    if (req_we) begin
                        bs_d.st  = BUS_WRITE;
                        bs_d.we  = 1'b1;
                        bs_d.adr = req_waddr;
                        bs_d.dat = req_wdata;
                    end else begin
                        bs_d.st  = BUS_READ;
                        bs_d.we  = 1'b0;
                        bs_d.adr = req_raddr;
                    end
                end
            end
            BUS_WRITE: begin
                if (ack || bs_q.cnt == CNT_LAST) begin
                    bs_d.st  = BUS_GAP;
                    bs_d.cyc = 1'b0;
                    bs_d.we  = 1'b0;
                end else begin
                    bs_d.cnt = bs_q.cnt + CNT_W'(1);
                end
            end
            BUS_GAP: begin
                bs_d.st  = BUS_READ;
                bs_d.cyc = 1'b1;
                bs_d.adr = req_raddr;
                bs_d.cnt = '0;
            end
            BUS_READ: begin
                if (ack || bs_q.cnt == CNT_LAST) begin
                    bs_d.rdata   = ack ? dat_i : '1;
                    bs_d.st      = BUS_IDLE;
                    bs_d.cyc     = 1'b0;
                    bs_d.ack_tgl = ~bs_q.ack_tgl;
                end else begin
                    bs_d.cnt = bs_q.cnt + CNT_W'(1);
                end
            end
            default: bs_d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '{st: BUS_IDLE, default: '0};
        else        bs_q <= bs_d;
    end

    assign ack_tgl = bs_q.ack_tgl;
    assign rdata   = bs_q.rdata;
    assign cyc     = bs_q.cyc;
    assign we      = bs_q.we;
    assign adr     = bs_q.adr;
    assign dat_o   = bs_q.dat;
endmodule

// File: rtl/jwb_bridge.sv
`timescale 1ns/1ps
module jwb_bridge
    import jwb_pkg::*;
#(
    parameter int ADDR_W      = 29,
    parameter int DATA_W      = 64,
    parameter int TMO_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic [IR_W-1:0]       ir_code,
    input  logic                  capture_dr,
    input  logic                  shift_dr,
    input  logic                  update_dr,
    input  logic                  tdi,
    output logic                  tdo,
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  wb_cyc_o,
    output logic                  wb_stb_o,
    output logic                  wb_we_o,
    output logic [DATA_W/8-1:0]   wb_sel_o,
    output logic [ADDR_W-1:0]     wb_adr_o,
    output logic [DATA_W-1:0]     wb_dat_o,
    input  logic [DATA_W-1:0]     wb_dat_i,
    input  logic                  wb_ack_i
);
    localparam int SEL_W = DATA_W / 8;

    logic              req_tgl, req_tgl_s, req_we;
    logic              ack_tgl, ack_tgl_s;
    logic [ADDR_W-1:0] req_waddr, req_raddr, cur_addr;
    logic [DATA_W-1:0] req_wdata, sys_rdata;
    logic              busy_tck;
    logic              bus_cyc;

    jwb_scan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) scan_i (
        .tck(tck), .trst_n(trst_n), .ir_code(ir_code),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .ack_tgl_s(ack_tgl_s), .sys_rdata(sys_rdata),
        .req_tgl(req_tgl), .req_we(req_we), .req_waddr(req_waddr),
        .req_raddr(req_raddr), .req_wdata(req_wdata),
        .cur_addr(cur_addr), .busy(busy_tck)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_tgl_s)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(tck), .rst_n(trst_n), .d(ack_tgl), .q(ack_tgl_s)
    );

    jwb_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYCLES(TMO_CYCLES)) bus_i (
        .clk(clk), .rst_n(rst_n), .req_tgl_s(req_tgl_s), .req_we(req_we),
        .req_waddr(req_waddr), .req_raddr(req_raddr), .req_wdata(req_wdata),
        .ack_tgl(ack_tgl), .rdata(sys_rdata), .cyc(bus_cyc), .we(wb_we_o),
        .adr(wb_adr_o), .dat_o(wb_dat_o), .dat_i(wb_dat_i), .ack(wb_ack_i)
    );

    assign wb_cyc_o = bus_cyc;
    assign wb_stb_o = bus_cyc;
    assign wb_sel_o = {SEL_W{1'b1}};
endmodule

// File: rtl/jwb_checker.sv
`timescale 1ns/1ps
module jwb_checker
    import jwb_pkg::*;
#(
    parameter int ADDR_W     = 29,
    parameter int DATA_W     = 64,
    parameter int TMO_CYCLES = 16
) (
    input logic              tck,
    input logic              trst_n,
    input logic [IR_W-1:0]   ir_code,
    input logic              update_dr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              busy_tck,
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc_o,
    input logic              wb_we_o,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic              wb_ack_i
);
    localparam int CW = $clog2(TMO_CYCLES + 2);
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (wb_cyc_o) run_q <= run_q + CW'(1);
        else               run_q <= '0;
    end

    logic data_op;
    assign data_op = (ir_code == OP_READ) || (ir_code == OP_RDWR);

    // R6: a data update moves the address on by exactly one word
    a_r6_addr_advance: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr && data_op |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    // R2: an unknown instruction leaves the address alone
    a_r2_unknown_no_effect: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr && !data_op && ir_code != OP_ADDR |=> $stable(cur_addr));

    // R3: input rule, an update only after the previous round trip closed
    a_r3_update_spacing: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr |-> !busy_tck);

    // R7: acknowledge closes the cycle on the next clock
    a_r7_ack_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o && wb_ack_i |=> !wb_cyc_o);

    // R7: request fields held while the cycle stays open
    a_r7_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o && $past(wb_cyc_o) |-> wb_adr_o == $past(wb_adr_o)
            && wb_we_o == $past(wb_we_o) && wb_dat_o == $past(wb_dat_o));

    // R7: write enable never outside a cycle
    a_r7_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we_o |-> wb_cyc_o);

    // R8: no cycle outlives the timeout
    a_r8_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> run_q < CW'(TMO_CYCLES));
endmodule

bind jwb_bridge jwb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYCLES(TMO_CYCLES)
) chk_i (
    .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .update_dr(update_dr),
    .cur_addr(cur_addr), .busy_tck(busy_tck), .clk(clk), .rst_n(rst_n),
    .wb_cyc_o(wb_cyc_o), .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o),
    .wb_dat_o(wb_dat_o), .wb_ack_i(wb_ack_i)
);

// File: tb/jwb_bridge_tb_top.sv
`timescale 1ns/1ps
module jwb_bridge_tb_top;
    localparam int AW  = 29;
    localparam int DW  = 64;
    localparam int TMO = 16;

    logic          tck = 0, trst_n = 0, clk = 0, rst_n = 0;
    logic [3:0]    ir_code = 0;
    logic          capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic          tdo;
    logic          wb_cyc_o, wb_stb_o, wb_we_o;
    logic [7:0]    wb_sel_o;
    logic [AW-1:0] wb_adr_o;
    logic [DW-1:0] wb_dat_o;
    logic [DW-1:0] wb_dat_i = '0;
    logic          wb_ack_i = 0;

    int vectors = 0, fails = 0;

    jwb_bridge dut_i (
        .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .clk(clk), .rst_n(rst_n), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
        .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
    );

    always #2.5 clk = ~clk;

    // memory model: sixteen words answer one clock after the strobe
    logic [DW-1:0] mem    [16];
    logic [DW-1:0] shadow [16];

    always @(posedge clk) begin
        if (wb_cyc_o && wb_stb_o && !wb_ack_i && wb_adr_o < AW'(16)) begin
            wb_ack_i <= 1'b1;
            wb_dat_i <= mem[wb_adr_o[3:0]];
            if (wb_we_o) mem[wb_adr_o[3:0]] <= wb_dat_o;
        end else begin
            wb_ack_i <= 1'b0;
        end
    end

    // bus monitor, sampled on the falling clock
    int cyc_starts = 0, writes = 0, proto_err = 0, run_len = 0, last_len = 0;
    logic          prev_cyc = 0;
    logic [AW-1:0] prev_adr = '0;
    always @(negedge clk) begin
        if (wb_cyc_o) begin
            if (!prev_cyc) cyc_starts++;
            run_len++;
            if (wb_sel_o !== 8'hFF || wb_stb_o !== 1'b1) proto_err++;
            if (prev_cyc && wb_adr_o !== prev_adr) proto_err++;
            if (wb_we_o && wb_ack_i) writes++;
        end else begin
            if (wb_we_o || wb_stb_o) proto_err++;
            if (prev_cyc) begin
                last_len = run_len;
                run_len  = 0;
            end
        end
        prev_cyc = wb_cyc_o;
        prev_adr = wb_adr_o;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tck_cycle();
        #50 tck = 1;
        #50 tck = 0;
    endtask

    task automatic scan(input logic [3:0] ir, input int nbits,
                        input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        ir_code = ir;
        capture_dr = 1; tck_cycle(); capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < nbits; i++) begin
            tdi = din[i];
            dout[i] = tdo;
            tck_cycle();
        end
        shift_dr = 0;
        update_dr = 1; tck_cycle(); update_dr = 0;
        repeat (12) tck_cycle();
    endtask

    task automatic t_reset();
        logic [63:0] o;
        check("R1 cyc after reset", 64'(wb_cyc_o), 64'd0);
        check("R1 we after reset", 64'(wb_we_o), 64'd0);
        check("R1 tdo after reset", 64'(tdo), 64'd0);
        scan(4'd5, AW, 64'd2, o);
        check("R1 R3 first address capture", o, 64'd0);
    endtask

    task automatic t_readwrite();
        logic [63:0] o;
        logic [63:0] a = 64'h0123_4567_89AB_CDEF;
        logic [63:0] b = 64'hFEDC_BA98_7654_3210;
        int w0;
        scan(4'd7, DW, a, o);
        check("R3 R5 old word at 2", o, shadow[2]);
        shadow[2] = a;
        scan(4'd7, DW, b, o);
        check("R5 R6 old word at 3", o, shadow[3]);
        shadow[3] = b;
        check("R5 two writes issued", 64'(writes), 64'd2);
        scan(4'd5, AW, 64'd2, o);
        check("R6 address after two scans", o, 64'd4);
        w0 = writes;
        scan(4'd6, DW, 64'hFFFF_FFFF_FFFF_FFFF, o);
        check("R9 R5 read back word 2", o, shadow[2]);
        scan(4'd6, DW, 64'h5555_5555_5555_5555, o);
        check("R4 read back word 3", o, shadow[3]);
        check("R4 no write during reads", 64'(writes), 64'(w0));
        check("R4 memory word 2 intact", mem[2], shadow[2]);
    endtask

    task automatic t_unknown();
        logic [63:0] o;
        int c0 = cyc_starts;
        scan(4'd3, DW, 64'hDEAD_BEEF_0000_0001, o);
        check("R2 no bus cycle for code 3", 64'(cyc_starts), 64'(c0));
        scan(4'd5, AW, 64'd4, o);
        check("R2 address unchanged by code 3", o, 64'd4);
    endtask

    task automatic t_timeout();
        logic [63:0] o;
        int w0;
        scan(4'd5, AW, 64'd20, o);
        scan(4'd6, DW, '0, o);
        check("R8 timed-out read gives ones", o, '1);
        check("R8 cycle length at timeout", 64'(last_len), 64'(TMO));
        w0 = writes;
        scan(4'd7, DW, 64'h1111_2222_3333_4444, o);
        check("R8 read-write at silent address", o, '1);
        check("R8 abandoned write not counted", 64'(writes), 64'(w0));
    endtask

    task automatic t_wrap();
        logic [63:0] o;
        scan(4'd5, AW, 64'h1FFF_FFFF, o);
        check("R9 capture before reload", o, 64'd22);
        scan(4'd6, DW, '0, o);
        check("R8 top address silent", o, '1);
        scan(4'd5, AW, 64'd0, o);
        check("R6 address wraps to zero", o, 64'd0);
        scan(4'd6, DW, '0, o);
        check("R6 R9 read word 0", o, shadow[0]);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]    = {32'hC0DE_0000 | 32'(i), 32'h0000_F00D ^ 32'(i)};
            shadow[i] = mem[i];
        end
        #103;
        trst_n = 1;
        rst_n  = 1;
        #200;
        t_reset();
        t_readwrite();
        t_unknown();
        t_timeout();
        t_wrap();
        check("R7 bus protocol monitor", 64'(proto_err), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule